// File: doc/BRIEF.md
# Gated IF Frequency Window Detector

This block measures the rate of an intermediate-frequency pulse train by counting its rising edges over a gate of fixed length, timed in reference-clock cycles. Once the gate has closed, it checks whether the count falls inside a window set by an inclusive lower bound and an inclusive upper bound. A single status pin reports the outcome. Software sets the window and the gate-length bit, raises the measurement enable, waits, and reads the status pin. Dropping the enable aborts or ends the measurement.

The status pin has two uses. While measurement is disabled it passes the station-detect input straight through. While measurement is enabled it stays low until the gate has closed, and after that it shows the window result. The IF input pull-down control is asserted whenever measurement is disabled. Every pin is a plain level signal. No data stream passes through the block, so it has no valid/ready handshake and no back-pressure.

Top module: `if_window_detector`

## Requirements
- R1: When `meas_en` is sampled high while the block is idle, a gate opens on the next cycle. Rising edges of `if_in`, after a two-flop synchroniser, are counted on every clock edge inside the gate.
- R2: When `meas_en` is sampled low, the block returns to idle and the edge count and the latched result are both cleared, even in the middle of a gate. A measurement that follows an abort gives the same result as one that follows a clean disable.
- R3: `gate_long` is captured when the gate opens. A value of 0 gives a gate of `GATE_CYC` reference cycles and a value of 1 gives `2*GATE_CYC` cycles, so the same input rate yields about twice the count.
- R4: While `meas_en` is 0, `status_out` equals `sd_in` combinationally.
- R5: While `meas_en` is 1 and the gate has not yet closed, `status_out` is 0 whatever `sd_in` is.
- R6: After the gate closes, `status_out` is 1 exactly when `win_lo <= count <= win_hi`, with both bounds inclusive, and 0 otherwise.
- R7: The edge count saturates at `2**CNT_W-1` and does not wrap.
- R8: `if_pulldown` is 1 exactly when `meas_en` is 0.
- R9: The result stays latched while `meas_en` remains high. A new measurement begins only after `meas_en` has been low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| if_in | input | 1 | IF pulse input (asynchronous) |
| sd_in | input | 1 | Station-detect input |
| meas_en | input | 1 | Measurement enable |
| gate_long | input | 1 | Gate-length select: 0 short, 1 long |
| win_lo | input | CNT_W | Inclusive lower bound of the window |
| win_hi | input | CNT_W | Inclusive upper bound of the window |
| status_out | output | 1 | Station-detect pass-through, or the measurement result |
| if_pulldown | output | 1 | IF input pull-down request |

## Verification
The exact count at the window edges is hard to predict from the ports, because the synchroniser delay decides which edges fall inside the gate. The stimulus therefore restarts an identical pulse pattern for every measurement. A first run finds the count, and later runs place `win_lo` or `win_hi` exactly on that count, or one step past it. Saturation is reached by toggling `if_in` every cycle across a long gate. An abort in mid-gate is followed by a full rerun, to show that nothing was left over from the aborted gate.

// File: rtl/ifwd_pkg.sv
package ifwd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_GATE = 2'd1,
    ST_DONE = 2'd2
  } meas_st_e;
endpackage

// File: rtl/ifwd_edge_sync.sv
module ifwd_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);
  logic [STAGES:0] shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shreg <= '0;
    else        shreg <= {shreg[STAGES-1:0], din};
  end

  // rising edge seen at the synchronised end of the chain
  assign rise = shreg[STAGES-1] & ~shreg[STAGES];
endmodule

// File: rtl/ifwd_gate_timer.sv
module ifwd_gate_timer #(
  parameter int GATE_CYC = 400
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic start,
  input  logic long_sel,
  output logic last
);
  localparam int LONG_CYC = 2 * GATE_CYC;
  localparam int TW       = $clog2(LONG_CYC + 1);

  logic [TW-1:0] tmr;
  logic          sel_q;
  logic          run;
  logic [TW-1:0] limit;

  assign limit = sel_q ? TW'(LONG_CYC - 1) : TW'(GATE_CYC - 1);
  assign last  = run && (tmr == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr   <= '0;
      sel_q <= 1'b0;
      run   <= 1'b0;
    end else if (clear) begin
      tmr <= '0;
      run <= 1'b0;
    end else if (start) begin
      tmr   <= '0;
      sel_q <= long_sel;
      run   <= 1'b1;
    end else if (run) begin
      if (last) run <= 1'b0;
      else      tmr <= tmr + 1'b1;
    end
  end
endmodule

// File: rtl/ifwd_sat_counter.sv
module ifwd_sat_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] cnt_nxt
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  assign cnt_nxt = (inc && cnt != CNT_MAX) ? cnt + 1'b1 : cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (clear) cnt <= '0;
    else            cnt <= cnt_nxt;
  end
endmodule

// File: rtl/if_window_detector.sv
module if_window_detector #(
  parameter int CNT_W    = 8,
  parameter int GATE_CYC = 400,
  parameter int SYNC_FF  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             if_in,
  input  logic             sd_in,
  input  logic             meas_en,
  input  logic             gate_long,
  input  logic [CNT_W-1:0] win_lo,
  input  logic [CNT_W-1:0] win_hi,
  output logic             status_out,
  output logic             if_pulldown
);
  import ifwd_pkg::*;

  meas_st_e         state, state_n;
  logic             rise;
  logic             last;
  logic             start;
  logic             in_win;
  logic [CNT_W-1:0] cnt, cnt_nxt;

  assign start = (state == ST_IDLE) && meas_en;

  ifwd_edge_sync #(.STAGES(SYNC_FF)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (if_in),
    .rise (rise)
  );

  ifwd_gate_timer #(.GATE_CYC(GATE_CYC)) u_gate (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (!meas_en),
    .start   (start),
    .long_sel(gate_long),
    .last    (last)
  );

  ifwd_sat_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (!meas_en || start),
    .inc    (rise && state == ST_GATE),
    .cnt    (cnt),
    .cnt_nxt(cnt_nxt)
  );

  always_comb begin
    state_n = state;
    unique case (state)
      ST_IDLE: if (meas_en) state_n = ST_GATE;
      ST_GATE: if (!meas_en) state_n = ST_IDLE;
               else if (last) state_n = ST_DONE;
      ST_DONE: if (!meas_en) state_n = ST_IDLE;
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      in_win <= 1'b0;
    end else begin
      state <= state_n;
      if (!meas_en)
        in_win <= 1'b0;
      else if (state == ST_GATE && last)
        in_win <= (cnt_nxt >= win_lo) && (cnt_nxt <= win_hi);
    end
  end

  assign status_out  = meas_en ? (state == ST_DONE && in_win) : sd_in;
  assign if_pulldown = !meas_en;
endmodule

// File: rtl/ifwd_checker.sv
module ifwd_checker #(
  parameter int CNT_W = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               meas_en,
  input logic               status_out,
  input ifwd_pkg::meas_st_e state,
  input logic [CNT_W-1:0]   cnt
);
  import ifwd_pkg::*;
  localparam logic [CNT_W-1:0] CMAX = '1;

  assert_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (meas_en && state == ST_IDLE) |=> (state == ST_GATE || !$past(meas_en) || !meas_en));

  assert_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !meas_en |=> (cnt == '0 && state == ST_IDLE));

  assert_low_in_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_GATE && meas_en) |-> !status_out);

  assert_no_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CMAX && state == ST_GATE && meas_en) |=> (cnt == CMAX));

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DONE && meas_en) |=> (!meas_en || $stable(status_out)));
endmodule

bind if_window_detector ifwd_checker #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .meas_en   (meas_en),
  .status_out(status_out),
  .state     (state),
  .cnt       (cnt)
);

// File: tb/if_window_detector_tb.sv
module if_window_detector_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 8;
  localparam int GATE       = 400;
  localparam int CMAX       = (1 << CNT_W) - 1;

  logic             clk = 0;
  logic             rst_n = 0;
  logic             if_in = 0, sd_in = 0, meas_en = 0, gate_long = 0;
  logic [CNT_W-1:0] win_lo = 0, win_hi = 0;
  logic             status_out, if_pulldown;

  int checks = 0, failures = 0;

  if_window_detector #(.CNT_W(CNT_W), .GATE_CYC(GATE)) u_dut (
    .clk(clk), .rst_n(rst_n), .if_in(if_in), .sd_in(sd_in),
    .meas_en(meas_en), .gate_long(gate_long), .win_lo(win_lo),
    .win_hi(win_hi), .status_out(status_out), .if_pulldown(if_pulldown)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference: 0 idle, 1 counting, 2 finished
  int  m_phase = 0, m_t = 0, m_len = 0, m_cnt = 0, m_final = 0;
  bit  m_win = 0;
  bit  hist[$] = '{0, 0, 0, 0};

  always @(posedge clk) begin
    if (!rst_n) begin
      m_phase = 0; m_cnt = 0; m_win = 0;
      hist = '{0, 0, 0, 0};
    end else begin
      bit r;
      hist.push_front(if_in);
      r = hist[2] && !hist[3];
      void'(hist.pop_back());
      case (m_phase)
        0: if (meas_en) begin
             m_phase = 1; m_t = 0; m_cnt = 0;
             m_len = gate_long ? 2*GATE : GATE;
           end
        1: if (!meas_en) begin m_phase = 0; m_cnt = 0; m_win = 0; end
           else begin
             if (r && m_cnt < CMAX) m_cnt++;
             if (m_t == m_len - 1) begin
               m_win = (m_cnt >= win_lo) && (m_cnt <= win_hi);
               m_final = m_cnt; m_phase = 2;
             end else m_t++;
           end
        default: if (!meas_en) begin m_phase = 0; m_cnt = 0; m_win = 0; end
      endcase
    end
  end

  // per-cycle comparison against the reference (R4, R5, R6, R8)
  always @(negedge clk) if (rst_n) begin
    chk("cycle-model status R6", status_out,
        meas_en ? int'(m_phase == 2 && m_win) : int'(sd_in));
    chk("cycle-model pulldown R8", if_pulldown, int'(!meas_en));
  end

  task automatic tick(); @(negedge clk); #1; endtask

  task automatic idle(int n);
    meas_en = 0; if_in = 0;
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic measure(int per, int hl, bit lg, int lo, int hi);
    int n;
    win_lo = CNT_W'(lo); win_hi = CNT_W'(hi); gate_long = lg;
    meas_en = 1; sd_in = 1;
    n = (lg ? 2*GATE : GATE) + 8;
    for (int c = 0; c < n; c++) begin
      if_in = (c % per) < hl;
      if (c == n/2) chk("R5 low while gating", status_out, 0);
      tick();
    end
    if_in = 0;
  endtask

  initial begin
    #(CLK_PERIOD*200000);
    failures++; checks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int base;
    #(CLK_PERIOD*3); tick();
    chk("reset R8 pulldown", if_pulldown, 1);
    chk("reset R4 status", status_out, 0);
    rst_n = 1; tick();

    sd_in = 1; #1; chk("R4 sd high", status_out, 1);
    sd_in = 0; #1; chk("R4 sd low", status_out, 0);
    idle(4);

    // R1: period 10 over a short gate gives about 40 edges
    measure(10, 5, 0, 0, CMAX);
    base = m_final;
    chk("R1 count near 40", int'(base >= 39 && base <= 41), 1);
    chk("R6 wide window", status_out, 1);
    for (int i = 0; i < 20; i++) tick();
    chk("R9 held", status_out, 1);
    chk("R8 pulldown off", if_pulldown, 0);
    idle(5);
    chk("R4 back to sd", status_out, int'(sd_in));

    measure(10, 5, 0, base, base); chk("R6 lo=hi=count", status_out, 1); idle(5);
    measure(10, 5, 0, base+1, CMAX); chk("R6 below lo", status_out, 0); idle(5);
    measure(10, 5, 0, 0, base-1); chk("R6 above hi", status_out, 0); idle(5);

    // R3 long gate
    measure(10, 5, 1, 0, CMAX);
    chk("R3 long gate doubles", int'(m_final >= 2*base-2 && m_final <= 2*base+2), 1);
    idle(5);

    // R7 saturation: 400 edges into an 8-bit count
    measure(2, 1, 1, CMAX, CMAX);
    chk("R7 saturated count", m_final, CMAX);
    chk("R7 result at max", status_out, 1);
    idle(5);

    // R2 abort mid-gate, then rerun
    win_lo = CNT_W'(base); win_hi = CNT_W'(base); meas_en = 1;
    for (int c = 0; c < GATE/2; c++) begin if_in = (c % 10) < 5; tick(); end
    meas_en = 0; if_in = 0; sd_in = 1; #1;
    chk("R2 abort pulldown", if_pulldown, 1);
    chk("R2 abort status=sd", status_out, 1);
    idle(5);
    measure(10, 5, 0, base, base);
    chk("R2 rerun same count", m_final, base);
    chk("R2 rerun result", status_out, 1);
    idle(5);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule